// File: doc/BRIEF.md
# Interleaved Four-Slot Round Scheduler

This block is the control and flow-control section of an iterative block-cipher core. It handles up to four independent 128-bit blocks at once, all sharing a single round loop. A slot tag circulates through a four-stage delay line that stands in for the round arithmetic. Each enabled clock edge brings one slot to the head of the loop. The scheduler then does one of three things with that slot: admits a new block into it if it is free, moves its round counter and round-key index forward, or retires it and pulses an output strobe.

A `start` pulse latches the direction and key size of the next session. Key sizes of 128, 192 and 256 bits need Nr = 10, 12 or 14 rounds. Encryption may begin in the cycle after `start`, before the key schedule has finished. In that case a slot waits in place whenever the round key it needs next has not yet been produced. Decryption starts only once the key schedule reports completion. Holding `enable` low freezes the whole block. Each slot keeps its own copy of direction and round count from the moment it was admitted.

Top module: `round_scheduler`

## Requirements
- R1: After reset `inReady` and `outValid` are 0 and every slot reads round 0, key index 0, not first, not last.
- R2: In encryption, a `start` pulse while the next head slot is free makes `inReady` 1 in the following cycle, even with `keyReady` low.
- R3: In decryption, `inReady` stays 0 until `keyReady` is sampled 1 at a clock edge; it is 1 in the cycle after that edge.
- R4: Key index tracks the round counter: for encryption it equals the round (1..Nr); for decryption it equals Nr minus the round (Nr-1..0). Admission sets round 1.
- R5: With no stall or pause, `outValid` is 1 in the cycle after the 4·Nr-th enabled edge following the admission edge, with Nr = 10, 12, 14 for `keyMode` 0, 1, 2.
- R6: `outValid` lasts one cycle per block, and `outSlot` names the slot that held the block. That slot reads round 0 in the same cycle.
- R7: Four blocks may be admitted on four consecutive edges. After that `inReady` is 0, because the next head slot is occupied.
- R8: While `enable` is 0, no round counter changes, no block is admitted and `outValid` stays 0. A completion that was due is delayed by the number of paused edges.
- R9: An encrypting slot at round r that is not at Nr holds its round while `keyReady` is 0 and `keyLevel` (the count of round keys already written) is at most r+1.
- R10: `slotFirst` bit s is 1 exactly while slot s is at round 1; `slotLast` bit s is 1 exactly while slot s is at round Nr.
- R11: `inValid` offered while `inReady` is 0 admits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Session start pulse; latches direction and key size |
| decrypt | input | 1 | 1 = decrypt, sampled with start |
| keyMode | input | 2 | 0: 128-bit, 1: 192-bit, 2/3: 256-bit key |
| keyReady | input | 1 | Key schedule complete |
| keyLevel | input | RND_W | Number of round keys written so far |
| enable | input | 1 | Global run; 0 pauses everything |
| inValid | input | 1 | A block is offered this cycle |
| inReady | output | 1 | Registered: an offer may be made this cycle |
| headSlot | output | TAG_W | Slot at the head of the loop this cycle |
| slotRound | output | NUM_SLOTS*RND_W | Per-slot round counter, slot s at bits s*RND_W |
| slotKeyIdx | output | NUM_SLOTS*RND_W | Per-slot round-key read index |
| slotFirst | output | NUM_SLOTS | Per-slot first-round flag |
| slotLast | output | NUM_SLOTS | Per-slot last-round flag |
| outValid | output | 1 | One-cycle completion strobe |
| outSlot | output | TAG_W | Slot whose block completed |

## Verification
Two functions can land on the same edge. The first pair is a slot's completion and a pause: the bench drops `enable` in the cycle just before the edge on which a block would retire. It then expects no strobe until the pause ends, and the due count shifts by exactly the paused edges. The second pair is retirement of one slot and admission into its neighbour during a four-deep back-to-back run. Here the scoreboard matches every strobe, in order, against the slot recorded at admission and against the enabled-edge count predicted from Nr.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

  typedef struct packed {
    logic shift;   // advance the loop by one position
    logic liveIn;  // occupancy of the slot re-entering the loop
  } loopCtl_t;

  function automatic int roundsFor(input logic [1:0] mode);
    case (mode)
      2'd0:    roundsFor = 10;
      2'd1:    roundsFor = 12;
      default: roundsFor = 14;
    endcase
  endfunction

endpackage

// File: rtl/rsched_loop.sv
module rsched_loop
  import rsched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int TAG_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  loopCtl_t         ctl,
  output logic [TAG_W-1:0] headTag,
  output logic [TAG_W-1:0] nextTag,
  output logic             headLive
);

  logic [TAG_W-1:0] tagQ  [NUM_SLOTS];
  logic             liveQ [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        tagQ[i]  <= TAG_W'(NUM_SLOTS - 1 - i);
        liveQ[i] <= 1'b0;
      end
    end else if (ctl.shift) begin
      tagQ[0]  <= tagQ[NUM_SLOTS-1];
      liveQ[0] <= ctl.liveIn;
      for (int i = 1; i < NUM_SLOTS; i++) begin
        tagQ[i]  <= tagQ[i-1];
        liveQ[i] <= liveQ[i-1];
      end
    end
  end

  assign headTag  = tagQ[NUM_SLOTS-1];
  assign nextTag  = tagQ[NUM_SLOTS-2];
  assign headLive = liveQ[NUM_SLOTS-1];

  // R7: the ring rotates one position per enabled edge
  a_r7_ring_rotates: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> headTag == $past(nextTag));
  // R8: a paused loop keeps its head
  a_r8_ring_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shift |=> $stable(headTag));

endmodule

// File: rtl/rsched_slot.sv
module rsched_slot #(
  parameter int RND_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serve,
  input  logic             admit,
  input  logic             decIn,
  input  logic [RND_W-1:0] nrIn,
  input  logic             keyReady,
  input  logic [RND_W-1:0] keyLevel,
  output logic             busy,
  output logic [RND_W-1:0] round,
  output logic [RND_W-1:0] keyIdx,
  output logic             isFirst,
  output logic             isLast,
  output logic             done
);

  logic             dec;
  logic [RND_W-1:0] nr;
  logic [RND_W:0]   nextRound;
  logic             keyOk, atEnd, step;

  assign nextRound = {1'b0, round} + 1'b1;
  assign keyOk     = keyReady | (!dec & ({1'b0, keyLevel} > nextRound));
  assign atEnd     = busy & (round == nr);
  assign done      = serve & atEnd;
  assign step      = serve & busy & !atEnd & keyOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      round  <= '0;
      keyIdx <= '0;
      dec    <= 1'b0;
      nr     <= '0;
    end else if (admit) begin
      busy   <= 1'b1;
      round  <= RND_W'(1);
      keyIdx <= decIn ? nrIn - 1'b1 : RND_W'(1);
      dec    <= decIn;
      nr     <= nrIn;
    end else if (done) begin
      busy   <= 1'b0;
      round  <= '0;
      keyIdx <= '0;
    end else if (step) begin
      round  <= round + 1'b1;
      keyIdx <= dec ? keyIdx - 1'b1 : keyIdx + 1'b1;
    end
  end

  assign isFirst = busy & (round == RND_W'(1));
  assign isLast  = atEnd;

  // R4: key index and round counter stay paired
  a_r4_key_pairing: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (dec ? (RND_W'(keyIdx + round) == nr) : (keyIdx == round)));
  // R5: a served slot with its key present advances by one
  a_r5_round_step: assert property (@(posedge clk) disable iff (!rstN)
    step |=> round == RND_W'($past(round) + 1'b1));
  // R9: a slot missing its next key holds its round
  a_r9_key_wait: assert property (@(posedge clk) disable iff (!rstN)
    (serve && busy && !atEnd && !keyOk) |=> round == $past(round));
  // R6: retirement frees the slot
  a_r6_slot_freed: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && round == '0);

endmodule

// File: rtl/rsched_ctrl.sv
module rsched_ctrl
  import rsched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int RND_W = 4,
  localparam int TAG_W = $clog2(NUM_SLOTS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic                              decrypt,
  input  logic [1:0]                        keyMode,
  input  logic                              keyReady,
  input  logic [RND_W-1:0]                  keyLevel,
  input  logic                              enable,
  input  logic                              inValid,
  input  logic [TAG_W-1:0]                  headTag,
  input  logic [TAG_W-1:0]                  nextTag,
  input  logic                              headLive,
  output loopCtl_t                          loopCtl,
  output logic                              inReady,
  output logic                              outValid,
  output logic [TAG_W-1:0]                  outSlot,
  output logic [NUM_SLOTS-1:0][RND_W-1:0]   roundArr,
  output logic [NUM_SLOTS-1:0][RND_W-1:0]   keyIdxArr,
  output logic [NUM_SLOTS-1:0]              firstArr,
  output logic [NUM_SLOTS-1:0]              lastArr
);

  logic             armed, modeDec;
  logic [RND_W-1:0] modeNr;
  logic             armedN, decN, modeOk, admitNow;
  logic [TAG_W-1:0] nextSel;

  logic [NUM_SLOTS-1:0] busy, busyNext, serveVec, admitVec, doneVec;

  assign modeOk   = armed & (!modeDec | keyReady);
  assign admitNow = enable & inValid & inReady & modeOk & !busy[headTag];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign serveVec[s] = enable & (headTag == TAG_W'(s));
    assign admitVec[s] = admitNow & (headTag == TAG_W'(s));

    rsched_slot #(.RND_W(RND_W)) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .serve    (serveVec[s]),
      .admit    (admitVec[s]),
      .decIn    (modeDec),
      .nrIn     (modeNr),
      .keyReady (keyReady),
      .keyLevel (keyLevel),
      .busy     (busy[s]),
      .round    (roundArr[s]),
      .keyIdx   (keyIdxArr[s]),
      .isFirst  (firstArr[s]),
      .isLast   (lastArr[s]),
      .done     (doneVec[s])
    );

    assign busyNext[s] = admitVec[s] | (busy[s] & !doneVec[s]);
  end

  assign armedN  = armed | start;
  assign decN    = start ? decrypt : modeDec;
  assign nextSel = enable ? nextTag : headTag;

  assign loopCtl.shift  = enable;
  assign loopCtl.liveIn = busyNext[headTag];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      modeDec  <= 1'b0;
      modeNr   <= RND_W'(10);
      inReady  <= 1'b0;
      outValid <= 1'b0;
      outSlot  <= '0;
    end else begin
      if (start) begin
        armed   <= 1'b1;
        modeDec <= decrypt;
        modeNr  <= RND_W'(roundsFor(keyMode));
      end
      inReady  <= armedN & (!decN | keyReady) & !busyNext[nextSel];
      outValid <= |doneVec;
      if (|doneVec) outSlot <= headTag;
    end
  end

  // R7: the loop's occupancy bit agrees with the slot that owns the head
  a_r7_live_matches: assert property (@(posedge clk) disable iff (!rstN)
    headLive == busy[headTag]);
  // R7: an advertised offer always finds the head slot free
  a_r7_ready_free: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !busy[headTag]);
  // R3: decryption readiness follows a sampled key-ready
  a_r3_dec_gate: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && modeDec) |-> $past(keyReady));
  // R8: pause freezes counters and output strobe
  a_r8_pause: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !outValid && $stable(roundArr));
  // R11: no occupancy growth without an accepted offer
  a_r11_no_admit: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && inValid && inReady) |=> $countones(busy) <= $countones($past(busy)));
  // R6: one strobe per block
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !(outValid && outSlot == $past(outSlot)));

endmodule

// File: rtl/round_scheduler.sv
module round_scheduler
  import rsched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int RND_W = 4,
  localparam int TAG_W = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       decrypt,
  input  logic [1:0]                 keyMode,
  input  logic                       keyReady,
  input  logic [RND_W-1:0]           keyLevel,
  input  logic                       enable,
  input  logic                       inValid,
  output logic                       inReady,
  output logic [TAG_W-1:0]           headSlot,
  output logic [NUM_SLOTS*RND_W-1:0] slotRound,
  output logic [NUM_SLOTS*RND_W-1:0] slotKeyIdx,
  output logic [NUM_SLOTS-1:0]       slotFirst,
  output logic [NUM_SLOTS-1:0]       slotLast,
  output logic                       outValid,
  output logic [TAG_W-1:0]           outSlot
);

  loopCtl_t         loopCtl;
  logic [TAG_W-1:0] headTag, nextTag;
  logic             headLive;
  logic [NUM_SLOTS-1:0][RND_W-1:0] roundArr, keyIdxArr;

  rsched_loop #(.NUM_SLOTS(NUM_SLOTS)) u_loop (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (loopCtl),
    .headTag  (headTag),
    .nextTag  (nextTag),
    .headLive (headLive)
  );

  rsched_ctrl #(.NUM_SLOTS(NUM_SLOTS), .RND_W(RND_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .decrypt   (decrypt),
    .keyMode   (keyMode),
    .keyReady  (keyReady),
    .keyLevel  (keyLevel),
    .enable    (enable),
    .inValid   (inValid),
    .headTag   (headTag),
    .nextTag   (nextTag),
    .headLive  (headLive),
    .loopCtl   (loopCtl),
    .inReady   (inReady),
    .outValid  (outValid),
    .outSlot   (outSlot),
    .roundArr  (roundArr),
    .keyIdxArr (keyIdxArr),
    .firstArr  (slotFirst),
    .lastArr   (slotLast)
  );

  assign headSlot   = headTag;
  assign slotRound  = roundArr;
  assign slotKeyIdx = keyIdxArr;

endmodule

// File: tb/round_scheduler_tb.sv
module round_scheduler_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, decrypt = 1'b0, keyReady = 1'b0, enable = 1'b1, inValid = 1'b0;
  logic [1:0] keyMode = 2'd0;
  logic [3:0] keyLevel = 4'd0;
  logic inReady, outValid;
  logic [1:0] headSlot, outSlot;
  logic [15:0] slotRound, slotKeyIdx;
  logic [3:0] slotFirst, slotLast;

  int checks = 0, errors = 0, enCount = 0, nr = 10, lastSlot = 0;
  int expSlot[$];
  int expDue[$];

  always #10 clk = ~clk;

  round_scheduler u_dut (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .keyMode(keyMode),
    .keyReady(keyReady), .keyLevel(keyLevel), .enable(enable), .inValid(inValid),
    .inReady(inReady), .headSlot(headSlot), .slotRound(slotRound), .slotKeyIdx(slotKeyIdx),
    .slotFirst(slotFirst), .slotLast(slotLast), .outValid(outValid), .outSlot(outSlot)
  );

  function automatic int rnd(input int s);
    return int'(slotRound[s*4 +: 4]);
  endfunction
  function automatic int kidx(input int s);
    return int'(slotKeyIdx[s*4 +: 4]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN && enable) enCount++;

  // monitor: pop and compare every completion strobe
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expSlot.size() == 0) begin
        chk(1'b0, "R6 unexpected outValid", 1, 0);
      end else begin
        int s, d;
        s = expSlot.pop_front();
        d = expDue.pop_front();
        chk(int'(outSlot) == s, "R6 outSlot", int'(outSlot), s);
        chk(enCount == d, "R5 completion edge", enCount, d);
        chk(rnd(int'(outSlot)) == 0, "R6 slot freed", rnd(int'(outSlot)), 0);
      end
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startSession(input bit dec, input logic [1:0] mode);
    decrypt = dec;
    keyMode = mode;
    nr = (mode == 2'd0) ? 10 : (mode == 2'd1) ? 12 : 14;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // driver: offer one block, push the expected completion
  task automatic admit(input int extra);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    lastSlot = int'(headSlot);
    expSlot.push_back(lastSlot);
    expDue.push_back(enCount + 1 + 4 * nr + extra);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    while (expSlot.size() != 0) @(negedge clk);
    waitEdges(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(inReady == 1'b0, "R1 inReady", int'(inReady), 0);
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(slotRound == '0 && slotKeyIdx == '0, "R1 slots idle", int'(slotRound), 0);
    chk(slotFirst == '0 && slotLast == '0, "R1 flags", int'(slotFirst), 0);
    rstN = 1'b1;
    @(negedge clk);

    // encryption, 128-bit, key not ready but all round keys present
    keyLevel = 4'd15;
    startSession(1'b0, 2'd0);
    chk(inReady == 1'b1, "R2 early enc ready", int'(inReady), 1);
    admit(0);
    chk(rnd(lastSlot) == 1, "R4 admit round", rnd(lastSlot), 1);
    chk(kidx(lastSlot) == 1, "R4 enc key idx", kidx(lastSlot), 1);
    chk(slotFirst[lastSlot] == 1'b1, "R10 first flag", int'(slotFirst[lastSlot]), 1);
    admit(0);
    admit(0);
    admit(0);
    chk(inReady == 1'b0, "R7 full loop", int'(inReady), 0);
    waitEdges(4);
    chk(rnd(lastSlot) == 2 && kidx(lastSlot) == 2, "R4 enc step", kidx(lastSlot), 2);
    chk(slotFirst[lastSlot] == 1'b0, "R10 first cleared", int'(slotFirst[lastSlot]), 0);
    drain();

    // decryption, 256-bit
    startSession(1'b1, 2'd2);
    chk(inReady == 1'b0, "R3 dec blocked", int'(inReady), 0);
    inValid = 1'b1;
    waitEdges(3);
    inValid = 1'b0;
    chk(slotRound == '0, "R11 offer ignored", int'(slotRound), 0);
    chk(inReady == 1'b0, "R3 still blocked", int'(inReady), 0);
    keyReady = 1'b1;
    waitEdges(1);
    chk(inReady == 1'b1, "R3 dec ready", int'(inReady), 1);
    admit(0);
    chk(kidx(lastSlot) == 13, "R4 dec key idx", kidx(lastSlot), 13);
    waitEdges(4 * 13);
    chk(rnd(lastSlot) == 14, "R5 reach Nr", rnd(lastSlot), 14);
    chk(slotLast[lastSlot] == 1'b1, "R10 last flag", int'(slotLast[lastSlot]), 1);
    chk(kidx(lastSlot) == 0, "R4 dec final idx", kidx(lastSlot), 0);
    drain();

    // pause colliding with completion, 192-bit encryption
    startSession(1'b0, 2'd1);
    admit(0);
    waitEdges(4 * 12 - 1);
    enable = 1'b0;
    inValid = 1'b1;
    begin
      int held;
      held = rnd(lastSlot);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(outValid == 1'b0, "R8 no output", int'(outValid), 0);
        chk(rnd(lastSlot) == held, "R8 round frozen", rnd(lastSlot), held);
      end
      chk($countones(slotRound) == $countones(slotRound[lastSlot*4 +: 4]),
          "R8 no admission", $countones(slotRound), $countones(slotRound[lastSlot*4 +: 4]));
    end
    inValid = 1'b0;
    enable = 1'b1;
    drain();

    // key-wait stall, 128-bit encryption with only two keys written
    keyReady = 1'b0;
    keyLevel = 4'd2;
    startSession(1'b0, 2'd0);
    admit(12);
    waitEdges(12);
    chk(rnd(lastSlot) == 1, "R9 held for key", rnd(lastSlot), 1);
    keyLevel = 4'd15;
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule